// File: doc/BRIEF.md
# Linked Watchpoint Event Qualifier

This block sits between the address comparators of a debug unit's data watchpoints and the logic that raises debug events. A watchpoint may stand alone, or it may be chained to a breakpoint unit that compares the current context identifier. A chained watchpoint fires only when the access address matches and that breakpoint unit accepts the current context. Address comparison and context comparison happen elsewhere. This block receives their results as single-bit hit inputs, together with each unit's control fields. It produces one registered event bit per watchpoint.

A chain is accepted only under four conditions. The target unit must exist. It must have context comparison hardware, which a parameter mask declares. It must be enabled. Its match-type field must select context matching with linking. In every other chained case the event is held low, so no case is left undefined. Any number of watchpoints may point at the same breakpoint unit, and each one is evaluated on its own.

Top module: `wp_link_qualifier`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `wp_event` is 0 after that edge.
- R2: `wp_event` is registered. Its value after an edge depends only on the inputs sampled at that edge.
- R3: A watchpoint whose link flag is 0 raises its event exactly when its enable and its address hit are both 1. All breakpoint inputs are ignored for it.
- R4: A watchpoint whose link flag is 1 raises its event exactly when all of the following hold: its enable is 1; its address hit is 1; the link index names a breakpoint unit below `NUM_BP`; that unit's bit in `BP_CTX_CAP` is 1; that unit's enable is 1; its 3-bit match type equals 3'b011; and its context hit is 1.
- R5: A watchpoint whose enable is 0 never raises its event, whatever its link settings are.
- R6: A linked watchpoint raises no event while its target breakpoint unit's enable is 0.
- R7: A linked watchpoint raises no event while its target's match type is any value other than 3'b011.
- R8: A linked watchpoint raises no event when its link index is `NUM_BP` or greater, because that unit is not implemented.
- R9: A linked watchpoint raises no event when its target's bit in `BP_CTX_CAP` is 0, even if every other condition holds.
- R10: Several watchpoints linked to the same breakpoint unit in the same cycle each produce the event that R4 gives for their own enable and address hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_en | input | NUM_WP | Per-watchpoint enable |
| wp_link_en | input | NUM_WP | Per-watchpoint link flag |
| wp_link_idx | input | NUM_WP*IDX_W | Link index; watchpoint w occupies bits [w*IDX_W +: IDX_W] |
| wp_addr_hit | input | NUM_WP | Per-watchpoint address comparator hit |
| bp_en | input | NUM_BP | Per-breakpoint enable |
| bp_mtype | input | NUM_BP*3 | Match type; unit b occupies bits [b*3 +: 3], 3'b011 selects linked context match |
| bp_ctx_hit | input | NUM_BP | Per-breakpoint context comparator hit |
| wp_event | output | NUM_WP | Qualified watchpoint event, registered |

## Verification
A wrong gate value for one breakpoint unit shows up one cycle later. It appears on every watchpoint whose index names that unit while that watchpoint's own enable and address hit are 1. A fault in the index decode shows up as an event that follows the hit of the wrong unit. Because the block has no state beyond the output register, every internal fault reaches the ports on the edge after the input pattern that exposes it. The bench therefore compares all event bits against its model on every cycle. It drives patterns that point several watchpoints at one unit, at units that lack the capability, and at indices beyond the last unit.

// File: rtl/wpl_pkg.sv
// Package: shared constants and helpers for the linked watchpoint qualifier.
// Assumes the breakpoint match-type field is three bits wide.
package wpl_pkg;

    localparam int unsigned MTYPE_W = 3;

    // Match-type code that selects context matching with linking enabled.
    localparam logic [MTYPE_W-1:0] MTYPE_CTX_LINKED = 3'b011;

    // True when a match-type field permits a watchpoint to chain to its unit.
    function automatic logic mtype_allows_link(input logic [MTYPE_W-1:0] mtype);
        return (mtype == MTYPE_CTX_LINKED);
    endfunction

endpackage

// File: rtl/wpl_bp_gate.sv
// Module: per-breakpoint link gate.
// Reduces one breakpoint unit's controls and context hit to a single bit.
// The bit says whether a watchpoint chained to this unit may fire now.
// Assumes CTX_CAPABLE is fixed at build time; when it is 0, the gate is always closed.
module wpl_bp_gate
    import wpl_pkg::*;
#(
    parameter bit CTX_CAPABLE = 1'b1
) (
    input  logic               bp_en,
    input  logic [MTYPE_W-1:0] bp_mtype,
    input  logic               bp_ctx_hit,
    output logic               link_ok
);

    // Purpose: combine capability, enable, match type and context hit.
    always_comb begin
        link_ok = CTX_CAPABLE
                & bp_en
                & mtype_allows_link(bp_mtype)
                & bp_ctx_hit;
    end

endmodule

// File: rtl/wpl_link_mux.sv
// Module: link index selector.
// Picks the gate bit of the breakpoint unit named by a link index.
// An index at or beyond NUM_BP matches no unit, so the result is 0.
// Assumes IDX_W is wide enough to name every implemented unit.
module wpl_link_mux #(
    parameter int unsigned NUM_BP = 6,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [IDX_W-1:0]  link_idx,
    input  logic [NUM_BP-1:0] gate_vec,
    output logic              sel_ok
);

    // Purpose: AND-OR one-hot selection; out-of-range indices select nothing.
    always_comb begin
        sel_ok = 1'b0;
        for (int b = 0; b < int'(NUM_BP); b++) begin
            if (link_idx == IDX_W'(b)) begin
                sel_ok = sel_ok | gate_vec[b];
            end
        end
    end

endmodule

// File: rtl/wpl_wp_eval.sv
// Module: per-watchpoint event decision.
// When unlinked, the event follows the watchpoint's enable and address hit.
// When linked, the selected breakpoint gate must also be open.
// Purely combinational; the top module registers the result.
module wpl_wp_eval (
    input  logic wp_en,
    input  logic wp_link_en,
    input  logic wp_addr_hit,
    input  logic sel_ok,
    output logic ev_next
);

    // Purpose: qualify the raw address hit with enable and, when linked, the gate.
    always_comb begin
        if (wp_link_en) begin
            ev_next = wp_en & wp_addr_hit & sel_ok;
        end else begin
            ev_next = wp_en & wp_addr_hit;
        end
    end

endmodule

// File: rtl/wp_link_qualifier.sv
// Module: linked watchpoint event qualifier (top).
// One gate per breakpoint unit and one selector plus evaluator per watchpoint.
// The event vector is registered with one cycle of latency and a synchronous
// active-low reset. BP_CTX_CAP marks which units have context comparison hardware.
module wp_link_qualifier
    import wpl_pkg::*;
#(
    parameter int unsigned         NUM_WP     = 4,
    parameter int unsigned         NUM_BP     = 6,
    parameter int unsigned         IDX_W      = 4,
    parameter logic [NUM_BP-1:0]   BP_CTX_CAP = 6'b110000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_WP-1:0]         wp_en,
    input  logic [NUM_WP-1:0]         wp_link_en,
    input  logic [NUM_WP*IDX_W-1:0]   wp_link_idx,
    input  logic [NUM_WP-1:0]         wp_addr_hit,
    input  logic [NUM_BP-1:0]         bp_en,
    input  logic [NUM_BP*MTYPE_W-1:0] bp_mtype,
    input  logic [NUM_BP-1:0]         bp_ctx_hit,
    output logic [NUM_WP-1:0]         wp_event
);

    localparam int unsigned MT_BUS_W = NUM_BP * MTYPE_W;

    logic [NUM_BP-1:0] gate_vec;
    logic [NUM_WP-1:0] sel_ok;
    logic [NUM_WP-1:0] ev_next;

    // One link gate per breakpoint unit, with its capability bit fixed by parameter.
    for (genvar b = 0; b < int'(NUM_BP); b++) begin : g_bp
        wpl_bp_gate #(
            .CTX_CAPABLE (BP_CTX_CAP[b])
        ) u_gate (
            .bp_en      (bp_en[b]),
            .bp_mtype   (bp_mtype[b*MTYPE_W +: MTYPE_W]),
            .bp_ctx_hit (bp_ctx_hit[b]),
            .link_ok    (gate_vec[b])
        );
    end

    // One selector and one evaluator per watchpoint.
    for (genvar w = 0; w < int'(NUM_WP); w++) begin : g_wp
        wpl_link_mux #(
            .NUM_BP (NUM_BP),
            .IDX_W  (IDX_W)
        ) u_mux (
            .link_idx (wp_link_idx[w*IDX_W +: IDX_W]),
            .gate_vec (gate_vec),
            .sel_ok   (sel_ok[w])
        );

        wpl_wp_eval u_eval (
            .wp_en       (wp_en[w]),
            .wp_link_en  (wp_link_en[w]),
            .wp_addr_hit (wp_addr_hit[w]),
            .sel_ok      (sel_ok[w]),
            .ev_next     (ev_next[w])
        );
    end

    // Purpose: register the qualified events; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_event <= '0;
        end else begin
            wp_event <= ev_next;
        end
    end

    // Purpose: build-time sanity check that every unit can be named by an index.
    initial begin
        if (MT_BUS_W != NUM_BP * 3 || (1 << IDX_W) < NUM_BP) begin
            $display("wp_link_qualifier: IDX_W too narrow for NUM_BP");
        end
    end

endmodule

// File: rtl/wpl_checker.sv
// Module: property checker for wp_link_qualifier, attached with bind.
// It decodes each watchpoint's target fields on its own and relates the
// inputs at one edge to the events after the next edge.
module wpl_checker #(
    parameter int unsigned       NUM_WP     = 4,
    parameter int unsigned       NUM_BP     = 6,
    parameter int unsigned       IDX_W      = 4,
    parameter logic [NUM_BP-1:0] BP_CTX_CAP = 6'b110000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_WP-1:0]       wp_en,
    input logic [NUM_WP-1:0]       wp_link_en,
    input logic [NUM_WP*IDX_W-1:0] wp_link_idx,
    input logic [NUM_WP-1:0]       wp_addr_hit,
    input logic [NUM_BP-1:0]       bp_en,
    input logic [NUM_BP*3-1:0]     bp_mtype,
    input logic [NUM_BP-1:0]       bp_ctx_hit,
    input logic [NUM_WP-1:0]       wp_event
);

    logic [NUM_WP-1:0] in_range, tgt_en, tgt_cap, tgt_mt_ok, tgt_ctx;

    // Purpose: look up each watchpoint's target unit fields.
    always_comb begin
        for (int w = 0; w < int'(NUM_WP); w++) begin
            in_range[w]  = int'(wp_link_idx[w*IDX_W +: IDX_W]) < int'(NUM_BP);
            tgt_en[w]    = 1'b0;
            tgt_cap[w]   = 1'b0;
            tgt_mt_ok[w] = 1'b0;
            tgt_ctx[w]   = 1'b0;
            for (int b = 0; b < int'(NUM_BP); b++) begin
                if (int'(wp_link_idx[w*IDX_W +: IDX_W]) == b) begin
                    tgt_en[w]    = bp_en[b];
                    tgt_cap[w]   = BP_CTX_CAP[b];
                    tgt_mt_ok[w] = (bp_mtype[b*3 +: 3] == 3'b011);
                    tgt_ctx[w]   = bp_ctx_hit[b];
                end
            end
        end
    end

    // R1: reset clears the events.
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (wp_event == '0));

    for (genvar w = 0; w < int'(NUM_WP); w++) begin : g_chk
        // R3 and R2: an unlinked event follows enable and hit one cycle later.
        p_unlinked_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !wp_link_en[w] |=> (wp_event[w] == $past(wp_en[w] & wp_addr_hit[w])));

        // R4: a fully qualified linked watchpoint fires.
        p_linked_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wp_link_en[w] && wp_en[w] && wp_addr_hit[w] && in_range[w] && tgt_cap[w]
             && tgt_en[w] && tgt_mt_ok[w] && tgt_ctx[w]) |=> wp_event[w]);

        // R5: a disabled watchpoint stays quiet.
        p_wp_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !wp_en[w] |=> !wp_event[w]);

        // R6: a disabled target blocks the event.
        p_bp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wp_link_en[w] && in_range[w] && !tgt_en[w]) |=> !wp_event[w]);

        // R7: the wrong match type blocks the event.
        p_mtype_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wp_link_en[w] && in_range[w] && !tgt_mt_ok[w]) |=> !wp_event[w]);

        // R8: an unimplemented target blocks the event.
        p_unimpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wp_link_en[w] && !in_range[w]) |=> !wp_event[w]);

        // R9: a target without context hardware blocks the event.
        p_nocap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wp_link_en[w] && in_range[w] && !tgt_cap[w]) |=> !wp_event[w]);
    end

endmodule

bind wp_link_qualifier wpl_checker #(
    .NUM_WP     (NUM_WP),
    .NUM_BP     (NUM_BP),
    .IDX_W      (IDX_W),
    .BP_CTX_CAP (BP_CTX_CAP)
) u_wpl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_en       (wp_en),
    .wp_link_en  (wp_link_en),
    .wp_link_idx (wp_link_idx),
    .wp_addr_hit (wp_addr_hit),
    .bp_en       (bp_en),
    .bp_mtype    (bp_mtype),
    .bp_ctx_hit  (bp_ctx_hit),
    .wp_event    (wp_event)
);

// File: tb/tb_wp_link_qualifier.sv
// Bench: drives inputs on the falling edge and computes the expected events
// with a behavioural model. It compares all event bits at the next falling edge.
module tb_wp_link_qualifier;

    localparam int unsigned       NWP = 4;
    localparam int unsigned       NBP = 6;
    localparam int unsigned       IW  = 4;
    localparam logic [NBP-1:0]    CAP = 6'b110000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NWP-1:0]     wp_en, wp_link_en, wp_addr_hit;
    logic [NWP*IW-1:0]  wp_link_idx;
    logic [NBP-1:0]     bp_en, bp_ctx_hit;
    logic [NBP*3-1:0]   bp_mtype;
    logic [NWP-1:0]     wp_event;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    logic [NWP-1:0] exp_ev;

    always #5 clk = ~clk;

    wp_link_qualifier #(
        .NUM_WP(NWP), .NUM_BP(NBP), .IDX_W(IW), .BP_CTX_CAP(CAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wp_en(wp_en), .wp_link_en(wp_link_en),
        .wp_link_idx(wp_link_idx), .wp_addr_hit(wp_addr_hit), .bp_en(bp_en),
        .bp_mtype(bp_mtype), .bp_ctx_hit(bp_ctx_hit), .wp_event(wp_event)
    );

    // Behavioural reference: the rule for each watchpoint, written from the requirements.
    function automatic logic [NWP-1:0] model();
        logic [NWP-1:0] r = '0;
        for (int w = 0; w < int'(NWP); w++) begin
            int i = int'(wp_link_idx[w*IW +: IW]);
            bit fire = wp_en[w] && wp_addr_hit[w];
            if (wp_link_en[w]) begin
                if (i >= int'(NBP)) fire = 0;
                else fire = fire && CAP[i] && bp_en[i] && bp_ctx_hit[i]
                            && (bp_mtype[i*3 +: 3] == 3'b011);
            end
            r[w] = fire;
        end
        return r;
    endfunction

    // Apply the current inputs, predict, then compare one clock later.
    task automatic step(input string tag);
        exp_ev = rst_n ? model() : '0;
        @(negedge clk);
        compared++;
        if (wp_event !== exp_ev) begin
            mismatched++;
            $display("FAIL %s: wp_event actual=%b expected=%b", tag, wp_event, exp_ev);
        end
    endtask

    task automatic set_idx(input int w, input int idx);
        wp_link_idx[w*IW +: IW] = IW'(idx);
    endtask

    task automatic set_mt(input int b, input logic [2:0] mt);
        bp_mtype[b*3 +: 3] = mt;
    endtask

    // A fully valid setup: every unit enabled, set to 3'b011, context hit.
    task automatic all_good();
        wp_en = '1; wp_addr_hit = '1; wp_link_en = '1;
        bp_en = '1; bp_ctx_hit = '1;
        for (int b = 0; b < int'(NBP); b++) set_mt(b, 3'b011);
        for (int w = 0; w < int'(NWP); w++) set_idx(w, 4);
    endtask

    initial begin
        rst_n = 1'b0;
        all_good();
        @(negedge clk);
        step("R1 reset state");
        step("R1 reset held with hits");
        rst_n = 1'b1;

        // R3: unlinked, various patterns; breakpoint inputs must not matter.
        wp_link_en = '0; bp_en = '0; bp_ctx_hit = '0;
        wp_en = 4'b1011; wp_addr_hit = 4'b1110; step("R3 unlinked pattern a");
        wp_en = 4'b1111; wp_addr_hit = 4'b0101; step("R3 unlinked pattern b");
        wp_en = 4'b0000; wp_addr_hit = 4'b1111; step("R5 all disabled unlinked");

        // R4 and R10: all watchpoints linked to capable unit 4.
        all_good(); step("R4 linked fire all");
        wp_addr_hit = 4'b1001; step("R10 shared target independent hits");
        wp_en = 4'b0110; wp_addr_hit = 4'b1111; step("R5 linked with some disabled");
        all_good(); for (int w = 0; w < int'(NWP); w++) set_idx(w, 4 + (w % 2));
        wp_addr_hit = 4'b0111; step("R10 two shared targets");

        // R6: target disabled.
        all_good(); bp_en[4] = 1'b0; step("R6 target disabled");
        // R7: every other match type.
        for (int m = 0; m < 8; m++) begin
            all_good(); set_mt(4, 3'(m));
            step(m == 3 ? "R4 mtype 011" : "R7 mtype other");
        end
        // Context hit low.
        all_good(); bp_ctx_hit[4] = 1'b0; step("R4 no context hit");
        // R8: out-of-range indices.
        for (int i = int'(NBP); i < 16; i++) begin
            all_good(); for (int w = 0; w < int'(NWP); w++) set_idx(w, i);
            step("R8 unimplemented target");
        end
        // R9: units without context capability.
        for (int i = 0; i < 4; i++) begin
            all_good(); for (int w = 0; w < int'(NWP); w++) set_idx(w, i);
            step("R9 target lacks capability");
        end

        // Mid-run reset.
        all_good(); rst_n = 1'b0; step("R1 mid-run reset");
        rst_n = 1'b1; step("R2 first cycle after reset");

        // Random patterns biased toward valid links.
        for (int n = 0; n < 3000; n++) begin
            wp_en = NWP'($urandom); wp_link_en = NWP'($urandom);
            wp_addr_hit = NWP'($urandom) | NWP'($urandom);
            bp_en = NBP'($urandom) | NBP'($urandom);
            bp_ctx_hit = NBP'($urandom) | NBP'($urandom);
            for (int b = 0; b < int'(NBP); b++)
                set_mt(b, ($urandom % 2) ? 3'b011 : 3'($urandom));
            for (int w = 0; w < int'(NWP); w++)
                set_idx(w, ($urandom % 4 != 0) ? 4 + int'($urandom % 2) : int'($urandom % 16));
            rst_n = ($urandom % 200) != 0;
            step("R4 random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule